// File: doc/BRIEF.md
# Indirect PHY Register Access Port

This block lets a host bus reach a private 8-bit PHY register file through only two host-visible words. The first is a command word. The second is a data word. A host write to the command word starts one transaction. Bit 8 of that write chooses whether the transaction is a store or a fetch, and the low byte names the PHY register.

While the transaction is running, a read-only busy bit in the command word stays high. The PHY file answers after a configurable number of cycles. When busy drops, the effect of the transaction is visible:

- For a store, the data word's low byte has been copied into the selected PHY register.
- For a fetch, the data word holds the contents of the selected PHY register.

Software prepares a store by first loading the data word and then issuing the command. A fetch needs only the command. In both cases software polls busy until it reads as zero.

Top module: `phy_indirect_port`

## Requirements
- R1: The command word decodes at host byte address 0x300 and the data word at 0x304. Reads of any other address return zero, and writes to any other address change nothing visible.
- R2: Reading the command word returns {6'b0, busy, write_flag, offset[7:0]}. Busy is bit 9, the write flag is bit 8 and the offset is bits 7:0, all taken from the last accepted command.
- R3: A command write made while idle raises busy from the next clock edge. Busy then stays high for exactly LATENCY cycles and clears by itself.
- R4: A command with bit 8 set stores the data word's low byte into the PHY register at the given offset. The store takes effect by the time busy clears.
- R5: A command with bit 8 clear loads the PHY register at the given offset into the data word. The value is readable once busy clears.
- R6: The data word keeps only bits 7:0 of a host write. Its bits 15:8 always read as zero.
- R7: A command write arriving while busy is high is dropped. No new transaction starts, the offset and flag read back unchanged, and the busy period is not extended.
- R8: A data write arriving while busy is high is dropped. A store in progress commits the value held at launch.
- R9: Active-low synchronous reset clears busy, the command word, the data word and every PHY register to zero.
- R10: LATENCY is at least 2, so every transaction shows busy on at least two host reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | BUS_AW | Host byte address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data for the current bus_addr (combinational) |

## Verification
The bench builds the block with LATENCY set to 3 instead of the default 4. This keeps transactions short, so many random stores and fetches fit in a run. It still leaves a busy window wide enough to inject a stray command or data write one cycle after launch. The bench then measures the shortened busy run, which exercises both the drop rules and the exact busy length. Offsets are biased toward a handful of registers, so fetches frequently return values written by earlier random stores.

// File: rtl/phy_indirect_port.sv
module phy_indirect_port #(
  parameter int LATENCY = 4,
  parameter int BUS_AW = 12,
  parameter logic [BUS_AW-1:0] CMD_ADDR = 12'h300,
  parameter logic [BUS_AW-1:0] DATA_ADDR = 12'h304
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata
);
  localparam int OFF_W = 8;
  localparam int PHY_DEPTH = 1 << OFF_W;
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [OFF_W-1:0] off_q;
  logic             wr_q;
  logic             busy_q;
  logic [7:0]       data_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       phy_mem [PHY_DEPTH];

  wire cmd_hit  = bus_we && (bus_addr == CMD_ADDR);
  wire data_hit = bus_we && (bus_addr == DATA_ADDR);
  wire launch   = cmd_hit && !busy_q;
  wire done     = busy_q && (cnt_q == '0);
  wire unused_wdata = &{1'b0, bus_wdata[15:9]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      wr_q   <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      if (launch) begin
        off_q  <= bus_wdata[OFF_W-1:0];
        wr_q   <= bus_wdata[8];
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(LATENCY - 1);
      end else if (done) begin
        busy_q <= 1'b0;
        if (!wr_q) data_q <= phy_mem[off_q];
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (data_hit && !busy_q) data_q <= bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHY_DEPTH; i++) phy_mem[i] <= '0;
    end else if (done && wr_q) begin
      phy_mem[off_q] <= data_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CMD_ADDR)       bus_rdata = {6'b0, busy_q, wr_q, off_q};
    else if (bus_addr == DATA_ADDR) bus_rdata = {8'b0, data_q};
  end
endmodule

// File: rtl/phy_indirect_port_chk.sv
module phy_indirect_port_chk #(
  parameter int LATENCY = 4,
  parameter int BUS_AW = 12,
  parameter logic [BUS_AW-1:0] CMD_ADDR = 12'h300,
  parameter logic [BUS_AW-1:0] DATA_ADDR = 12'h304
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [15:0]       bus_rdata,
  input logic              busy,
  input logic              wr,
  input logic [7:0]        off,
  input logic [7:0]        data
);
  int run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  initial begin
    assert_min_latency_R10: assert (LATENCY >= 2);
  end

  assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == LATENCY);

  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_we && bus_addr == CMD_ADDR));

  assert_cmd_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && bus_addr == CMD_ADDR) |=> ($stable(off) && $stable(wr) && run_q != 0));

  assert_data_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && bus_we && bus_addr == DATA_ADDR) |=> $stable(data));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == DATA_ADDR) |-> bus_rdata[15:8] == 8'h00);

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (!busy && data == 8'h00 && off == 8'h00 && !wr));
endmodule

bind phy_indirect_port phy_indirect_port_chk #(
  .LATENCY(LATENCY), .BUS_AW(BUS_AW), .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .busy(busy_q), .wr(wr_q), .off(off_q), .data(data_q)
);

// File: tb/tb_phy_indirect_port.sv
module tb_phy_indirect_port;
  localparam int LAT = 3;
  localparam logic [11:0] CMD = 12'h300;
  localparam logic [11:0] DAT = 12'h304;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] exp_mem [256];
  logic [15:0] exp_cmd;
  logic [7:0] exp_data;

  phy_indirect_port #(.LATENCY(LAT)) dut (.*);

  always #10 clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(logic [11:0] a, logic [15:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic brd(logic [11:0] a, output logic [15:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic wait_done(output int n);
    logic [15:0] v;
    n = 0;
    forever begin
      brd(CMD, v);
      if (!v[9] || n > 50) break;
      n++;
      @(posedge clk); #1;
    end
  endtask

  function automatic logic [15:0] cmd_word(logic w, logic [7:0] o);
    return {6'b0, 1'b0, w, o};
  endfunction

  task automatic phy_write(logic [7:0] o, logic [15:0] d);
    int n;
    bwr(DAT, d);
    bwr(CMD, cmd_word(1'b1, o));
    wait_done(n);
    check("R3 busy cycles", 16'(n), 16'(LAT));
    exp_mem[o] = d[7:0];
    exp_data = d[7:0];
    exp_cmd = cmd_word(1'b1, o);
  endtask

  task automatic phy_read(logic [7:0] o);
    int n;
    logic [15:0] v;
    bwr(CMD, cmd_word(1'b0, o));
    wait_done(n);
    check("R3 busy cycles", 16'(n), 16'(LAT));
    exp_data = exp_mem[o];
    exp_cmd = cmd_word(1'b0, o);
    brd(DAT, v); check("R5 fetched value", v, {8'h00, exp_mem[o]});
    brd(CMD, v); check("R2 command readback", v, exp_cmd);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;

    // R9: assert reset over several edges, then release
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    brd(CMD, v); check("R9 command after reset", v, 16'h0000);
    brd(DAT, v); check("R9 data after reset", v, 16'h0000);
    phy_read(8'h55);
    check("R9 phy reg after reset", {8'h00, exp_mem[8'h55]}, 16'h0000);

    // R4, R6: store with upper data bits set; only the low byte is kept
    bwr(DAT, 16'hABCD);
    brd(DAT, v); check("R6 upper bits zero", v, 16'h00CD);
    phy_write(8'h10, 16'hABCD);
    brd(CMD, v); check("R2 store command readback", v, 16'h0110);
    phy_read(8'h10);
    check("R4 stored value", {8'h00, exp_data}, 16'h00CD);

    // R1: writes to other addresses change nothing; reads return zero
    bwr(12'h308, 16'h01FF);
    bwr(12'h302, 16'h03FF);
    brd(12'h308, v); check("R1 unmapped read", v, 16'h0000);
    brd(12'h000, v); check("R1 unmapped read low", v, 16'h0000);
    brd(CMD, v); check("R1 command unchanged", v, exp_cmd);
    brd(DAT, v); check("R1 data unchanged", v, {8'h00, exp_data});

    // R7: a second command during busy is dropped
    bwr(CMD, cmd_word(1'b0, 8'h10));
    bwr(CMD, cmd_word(1'b1, 8'h20));
    wait_done(n);
    check("R7 busy not extended", 16'(n), 16'(LAT - 1));
    brd(CMD, v); check("R7 command unchanged", v, cmd_word(1'b0, 8'h10));
    brd(DAT, v); check("R7 fetch result", v, 16'h00CD);
    exp_data = 8'hCD;
    phy_read(8'h20);

    // R8: a data write during a store is dropped
    bwr(DAT, 16'h0033);
    bwr(CMD, cmd_word(1'b1, 8'h40));
    bwr(DAT, 16'h0077);
    wait_done(n);
    brd(DAT, v); check("R8 data unchanged", v, 16'h0033);
    exp_mem[8'h40] = 8'h33;
    phy_read(8'h40);

    // R4, R5: offset boundaries
    phy_write(8'hFF, 16'h005A);
    phy_write(8'h00, 16'h00A5);
    phy_read(8'hFF);
    phy_read(8'h00);

    // Random stores and fetches, biased toward a few offsets
    for (int i = 0; i < 120; i++) begin
      logic [7:0] o;
      o = ($urandom % 2) ? 8'($urandom % 8) : 8'($urandom % 256);
      if ($urandom % 2) phy_write(o, 16'($urandom));
      else phy_read(o);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule